// File: doc/BRIEF.md
# Addressed SPI Slave Register File

This block lets a host reach a bank of 128 sixteen-bit registers over a four-wire SPI link. The host pulls the active-low select low and clocks in a 12-bit command header on MOSI. The header gives a 7-bit register index, a 2-bit operation code, a 2-bit device identifier and one reserved bit. The block compares the identifier with its own 2-bit strap input. Only on a match does it enable its MISO driver, so several such blocks can sit on one select line and only the addressed one answers.

A read header makes the block shift the selected register out on MISO, most significant bit first. A write header makes it take the next 16 MOSI bits and store them into the selected register. A local write port on the system clock side also loads registers directly. The SPI pins are asynchronous to the system clock. They pass through synchronisers, and the block detects SCLK edges in the system clock domain (SPI mode 0).

Top module: `spi_rf_top`

## Requirements
- R1: After reset every register reads as 0x0000 and `spi_miso_oe` is low.
- R2: A header is 12 bits, taken on rising SCLK. In arrival order it holds the register index (7 bits, MSB first), the operation code (2 bits), the device identifier (2 bits) and one reserved bit.
- R3: `spi_miso_oe` stays low during the header. It goes high only after a complete read header whose identifier equals `dev_id`. A frame with any other identifier drives nothing and changes no register.
- R4: Operation code 2'b10 (read) puts bit 15 of the addressed register on `spi_miso` after the 12th rising SCLK edge. Each following falling SCLK edge moves to the next lower bit. The host samples 16 bits on the next 16 rising edges.
- R5: Operation code 2'b01 (write) collects the next 16 MOSI bits, MSB first, and stores them into the addressed register once the 16th bit arrives. `spi_miso_oe` stays low for the whole frame.
- R6: A header with operation code 2'b00 or 2'b11, or with the reserved bit set to 1, is ignored until select rises. No register changes and MISO is not driven.
- R7: While `spi_sel_n` is high, SCLK and MOSI activity has no effect. Raising `spi_sel_n` aborts any partial frame, with no register change, and drops `spi_miso_oe` within 4 clock cycles.
- R8: A one-cycle pulse on `lw_en` stores `lw_data` into register `lw_addr`. If an SPI write completes in the same cycle, the SPI write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 2 | Strap value this device answers to |
| spi_sel_n | input | 1 | Active-low select from the host |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Host-to-device data |
| spi_miso | output | 1 | Device-to-host data, valid while `spi_miso_oe` is high |
| spi_miso_oe | output | 1 | MISO driver enable; low means high impedance |
| lw_en | input | 1 | Local write strobe |
| lw_addr | input | 7 | Local write register index |
| lw_data | input | 16 | Local write data |

## Verification
Each SPI pin crosses two synchroniser flops and one edge-detect flop. A MOSI bit is therefore taken about 3 clocks after its rising SCLK edge. A new MISO bit appears about 4 clocks after a falling edge. A write lands about 4 clocks after the 16th data edge. The output enable drops about 3 to 4 clocks after select rises.

The bench holds each SCLK level for 8 clocks. It samples MISO and the enable on the last clock before each rising edge, so every result has settled before it is read. After raising select it waits 6 clocks before the next check. A scoreboard queues the register value that each read frame should return and compares it when the captured word arrives.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  typedef enum logic [1:0] {
    ST_HDR   = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_SKIP  = 2'd3
  } frame_st_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  // Header is usable for the given operation only when the reserved bit is 0.
  function automatic logic op_is(input logic [1:0] op, input logic rsv,
                                 input logic [1:0] want);
    return (op == want) && !rsv;
  endfunction

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/spi_rf_bank.sv
module spi_rf_bank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_we,
  input  logic [ADDR_W-1:0] spi_waddr,
  input  logic [DATA_W-1:0] spi_wdata,
  input  logic              lw_en,
  input  logic [ADDR_W-1:0] lw_addr,
  input  logic [DATA_W-1:0] lw_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (spi_we) begin
      regs[spi_waddr] <= spi_wdata;
    end else if (lw_en) begin
      regs[lw_addr] <= lw_data;
    end
  end

  assign rd_data = regs[rd_addr];

  // R5
  bank_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_we |=> regs[$past(spi_waddr)] == $past(spi_wdata));

  // R8
  local_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_en && !spi_we) |=> regs[$past(lw_addr)] == $past(lw_data));

endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int DEV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [DEV_W-1:0]  dev_id,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso,
  output logic              miso_oe
);

  localparam int HDR_LEN = ADDR_W + 2 + DEV_W + 1;
  localparam int MAX_LEN = (HDR_LEN > DATA_W) ? HDR_LEN : DATA_W;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_LEN - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

  frame_st_e         st;
  logic              sclk_q;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_LEN-2:0] hdr_sh;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-2:0] rx_sh;
  logic [ADDR_W-1:0] addr_q;
  logic              armed;

  // Named events for the assertions.
  logic               rise_evt, fall_evt, hdr_done, dev_match, go_read, go_write;
  logic [HDR_LEN-1:0] hdr_full;
  logic               f_rsv;
  logic [DEV_W-1:0]   f_dev;
  logic [1:0]         f_op;
  logic [ADDR_W-1:0]  f_addr;

  assign rise_evt  = !sel_n_s &&  sclk_s && !sclk_q;
  assign fall_evt  = !sel_n_s && !sclk_s &&  sclk_q;
  assign hdr_full  = {hdr_sh, mosi_s};
  assign f_rsv     = hdr_full[0];
  assign f_dev     = hdr_full[DEV_W:1];
  assign f_op      = hdr_full[DEV_W+2:DEV_W+1];
  assign f_addr    = hdr_full[HDR_LEN-1:DEV_W+3];
  assign hdr_done  = rise_evt && (st == ST_HDR) && (cnt == HDR_LAST);
  assign dev_match = (f_dev == dev_id);
  assign go_read   = hdr_done && dev_match && op_is(f_op, f_rsv, OP_READ);
  assign go_write  = hdr_done && dev_match && op_is(f_op, f_rsv, OP_WRITE);
  assign rd_addr   = f_addr;
  assign wr_addr   = addr_q;
  assign miso      = miso_oe ? tx_sh[DATA_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_HDR;
      sclk_q  <= 1'b0;
      cnt     <= '0;
      hdr_sh  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      addr_q  <= '0;
      armed   <= 1'b0;
      miso_oe <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      sclk_q <= sclk_s;
      wr_en  <= 1'b0;
      if (sel_n_s) begin
        st      <= ST_HDR;
        cnt     <= '0;
        armed   <= 1'b0;
        miso_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_HDR: if (rise_evt) begin
            hdr_sh <= hdr_full[HDR_LEN-2:0];
            cnt    <= cnt + 1'b1;
            if (hdr_done) begin
              cnt    <= '0;
              addr_q <= f_addr;
              if (go_read) begin
                st      <= ST_READ;
                tx_sh   <= rd_data;
                miso_oe <= 1'b1;
              end else if (go_write) begin
                st <= ST_WRITE;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_READ: begin
            if (rise_evt) armed <= 1'b1;
            else if (fall_evt && armed) begin
              tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
              armed <= 1'b0;
            end
          end
          ST_WRITE: if (rise_evt) begin
            rx_sh <= {rx_sh[DATA_W-3:0], mosi_s};
            cnt   <= cnt + 1'b1;
            if (cnt == DAT_LAST) begin
              wr_en   <= 1'b1;
              wr_data <= {rx_sh, mosi_s};
              st      <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  oe_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(go_read));

  // R3
  header_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR) |-> !miso_oe);

  // R4
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && !fall_evt && !sel_n_s) |=> $stable(miso));

  // R5
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || st == ST_WRITE) |-> !miso_oe);

  // R6
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |=> !wr_en);

  // R7
  sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |=> (!miso_oe && st == ST_HDR));

endmodule

// File: rtl/spi_rf_top.sv
module spi_rf_top #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int DEV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  dev_id,
  input  logic              spi_sel_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              lw_en,
  input  logic [ADDR_W-1:0] lw_addr,
  input  logic [DATA_W-1:0] lw_data
);

  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  spi_rf_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_sel_n, spi_sclk, spi_mosi}),
    .dout (pins_s)
  );

  spi_rf_frame #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEV_W (DEV_W)
  ) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_n_s(pins_s[2]),
    .sclk_s (pins_s[1]),
    .mosi_s (pins_s[0]),
    .dev_id (dev_id),
    .rd_data(rd_data),
    .rd_addr(rd_addr),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .miso   (spi_miso),
    .miso_oe(spi_miso_oe)
  );

  spi_rf_bank #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_we   (wr_en),
    .spi_waddr(wr_addr),
    .spi_wdata(wr_data),
    .lw_en    (lw_en),
    .lw_addr  (lw_addr),
    .lw_data  (lw_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

endmodule

// File: tb/tb_spi_rf_top.sv
module tb_spi_rf_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  dev_id = 2'd2;
  logic        spi_sel_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic        lw_en = 1'b0;
  logic [6:0]  lw_addr = '0;
  logic [15:0] lw_data = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] model [128];
  logic [15:0] exp_q [$];
  logic [15:0] got_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rf_top dut (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id),
    .spi_sel_n(spi_sel_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .lw_en(lw_en), .lw_addr(lw_addr), .lw_data(lw_data)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One SPI frame, mode 0. nd data bits follow the 12 header bits.
  task automatic xfer(input logic [6:0] a, input logic [1:0] op,
                      input logic [1:0] dv, input logic rsv,
                      input logic [15:0] wd, input int nd,
                      output logic [15:0] rd, output bit hdr_oe,
                      output bit dat_any, output bit dat_all);
    logic [11:0] hdr;
    hdr = {a, op, dv, rsv};
    rd = '0; hdr_oe = 0; dat_any = 0; dat_all = 1;
    spi_sel_n = 1'b0;
    for (int i = 0; i < 12; i++) begin
      spi_mosi = hdr[11-i];
      wait_clk(HALF);
      hdr_oe |= spi_miso_oe;
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
    for (int j = 0; j < nd; j++) begin
      spi_mosi = wd[15-j];
      wait_clk(HALF);
      rd = {rd[14:0], spi_miso};
      dat_any |= spi_miso_oe;
      dat_all &= spi_miso_oe;
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
    wait_clk(HALF);
    spi_sel_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic spi_read(input logic [6:0] a, input string tag);
    logic [15:0] rd; bit h, any, all;
    exp_q.push_back(model[a]);
    tag_q.push_back(tag);
    xfer(a, 2'b10, dev_id, 1'b0, 16'h0, 16, rd, h, any, all);
    check(!h, "R3 oe low during header", 32'(h), 0);
    check(all, "R4 oe high for all data bits", 32'(all), 1);
    got_q.push_back(rd);
  endtask

  task automatic spi_write(input logic [6:0] a, input logic [15:0] d);
    logic [15:0] rd; bit h, any, all;
    xfer(a, 2'b01, dev_id, 1'b0, d, 16, rd, h, any, all);
    model[a] = d;
    check(!h && !any, "R5 oe low during write", 32'(h | any), 0);
  endtask

  // Monitor: pops expected values as captured words arrive.
  initial begin
    forever begin
      wait (got_q.size() != 0);
      begin
        logic [15:0] g, e; string t;
        g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        check(g == e, t, 32'(g), 32'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    logic [15:0] rd; bit h, any, all;
    for (int i = 0; i < 128; i++) model[i] = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    check(spi_miso_oe == 1'b0, "R1 oe after reset", 32'(spi_miso_oe), 0);
    spi_read(7'd0,   "R1 reg 0 after reset");
    spi_read(7'd127, "R1 reg 127 after reset");

    // R2 R4 R5 write then read several patterns
    spi_write(7'd5,   16'hA5C3);
    spi_write(7'd127, 16'h8001);
    spi_write(7'd0,   16'hFFFF);
    spi_write(7'd64,  16'h1234);
    spi_read(7'd5,   "R4 read A5C3");
    spi_read(7'd127, "R2 read top index");
    spi_read(7'd0,   "R4 read all ones");
    spi_read(7'd64,  "R2 read 64");

    // R3 wrong device identifier
    xfer(7'd5, 2'b10, 2'd1, 1'b0, 16'h0, 16, rd, h, any, all);
    check(!h && !any, "R3 wrong id read drives nothing", 32'(h | any), 0);
    xfer(7'd5, 2'b01, 2'd1, 1'b0, 16'h0000, 16, rd, h, any, all);
    check(!any, "R3 wrong id write no drive", 32'(any), 0);
    spi_read(7'd5, "R3 wrong id write left reg");

    // R6 illegal headers
    xfer(7'd5, 2'b01, dev_id, 1'b1, 16'h1111, 16, rd, h, any, all);
    check(!any, "R6 reserved set no drive", 32'(any), 0);
    xfer(7'd5, 2'b00, dev_id, 1'b0, 16'h2222, 16, rd, h, any, all);
    check(!any, "R6 op 00 no drive", 32'(any), 0);
    xfer(7'd5, 2'b11, dev_id, 1'b0, 16'h3333, 16, rd, h, any, all);
    check(!any, "R6 op 11 no drive", 32'(any), 0);
    xfer(7'd5, 2'b10, dev_id, 1'b1, 16'h0, 16, rd, h, any, all);
    check(!any, "R6 reserved read no drive", 32'(any), 0);
    spi_read(7'd5, "R6 register unchanged");

    // R7 activity with select high
    for (int k = 0; k < 20; k++) begin
      spi_mosi = k[0];
      spi_sclk = ~spi_sclk;
      wait_clk(HALF);
    end
    spi_sclk = 1'b0;
    wait_clk(HALF);
    check(spi_miso_oe == 1'b0, "R7 oe with select high", 32'(spi_miso_oe), 0);
    spi_read(7'd64, "R7 read after idle noise");

    // R7 abort of a partial write
    xfer(7'd64, 2'b01, dev_id, 1'b0, 16'h00FF, 8, rd, h, any, all);
    spi_read(7'd64, "R7 partial write aborted");

    // R7 abort mid read releases the bus
    xfer(7'd0, 2'b10, dev_id, 1'b0, 16'h0, 5, rd, h, any, all);
    check(all, "R7 oe driven before abort", 32'(all), 1);
    check(spi_miso_oe == 1'b0, "R7 oe released after abort", 32'(spi_miso_oe), 0);

    // R8 local write port
    lw_addr = 7'd9; lw_data = 16'h0F0F; lw_en = 1'b1;
    wait_clk(1);
    lw_en = 1'b0;
    model[9] = 16'h0F0F;
    wait_clk(2);
    spi_read(7'd9, "R8 local write visible");

    // R2 strap change
    dev_id = 2'd3;
    wait_clk(2);
    spi_read(7'd127, "R2 read with new strap");

    wait (got_q.size() == 0);
    wait_clk(4);
    done = 1'b1;
    summary();
  end

endmodule